// File: doc/BRIEF.md
# Time-Binned Segmented Event Queue

This block keeps pending simulation events in a priority queue ordered by timestamp. Time ahead of a moving base is cut into a fixed number of consecutive windows of equal width. Each window owns a small bucket of slots. An insert only computes which window the timestamp falls in and appends the event to that bucket, so an insert costs one cycle no matter how many events are queued. The buckets sit on a circular ring, and the bucket for the earliest window is the head.

Events in a bucket stay in arrival order until that bucket becomes the head. The head bucket is then sorted in place by a sequential insertion sort that places one element per cycle. Pops come from the front of the sorted head. When the head has been drained and later windows still hold events, the base time moves forward by one window and the next bucket on the ring becomes the head. An event inserted into the head after its sort has finished goes straight to its ordered position.

A consumer takes events through a valid/ready pop port. A producer drives single-cycle inserts and sees one-cycle reject pulses for events that are out of range or that target a full bucket.

Top module: `tbin_evq`

## Requirements
- R1: After reset, empty is 1, full is 0, pop_valid is 0, both reject pulses are 0, and the base time is 0.
- R2: An insert goes to window index (ins_time - base_time) >> SEG_SHIFT, computed modulo 2^TIME_W. An index of NUM_SEG or more, which includes any time below the base, is dropped, and ins_overflow is 1 for the one cycle after the insert.
- R3: An insert whose window already holds SEG_CAP events is dropped, and ins_seg_full is 1 for the one cycle after the insert. This uses the count held before that cycle, even if a pop happens in the same cycle.
- R4: Pops return events in ascending timestamp order. Events with equal timestamps come out in the order they were inserted.
- R5: pop_valid is 0 while the head bucket is unsorted. With no insert arriving during the sort, pop_valid rises within SEG_CAP+2 cycles after the previous head emptied. It is never 0 for more than 2*SEG_CAP consecutive cycles while the head holds events.
- R6: When the head bucket is empty and other buckets hold events, the base time advances by 2^SEG_SHIFT and the next bucket on the ring becomes the head.
- R7: An insert into a head bucket whose sort has finished is placed in ordered position. It can then be popped before events with later timestamps that were inserted earlier.
- R8: empty is 1 exactly when no events are held. full is 1 exactly when NUM_SEG*SEG_CAP events are held.
- R9: pop_ready while pop_valid is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert strobe, one event per cycle |
| ins_time | input | TIME_W | Timestamp of the inserted event |
| ins_data | input | DATA_W | Payload of the inserted event |
| ins_overflow | output | 1 | Pulse: last insert was outside the window range |
| ins_seg_full | output | 1 | Pulse: last insert targeted a full bucket |
| pop_valid | output | 1 | Earliest event is available |
| pop_ready | input | 1 | Consumer takes the event when pop_valid is 1 |
| pop_time | output | TIME_W | Timestamp of the earliest event |
| pop_data | output | DATA_W | Payload of the earliest event |
| full | output | 1 | All buckets are full |
| empty | output | 1 | No events are held |

## Verification
The bench inserts events out of order across all windows, including a timestamp tie. A design with an unstable or broken sort would swap the tied payloads or release later times early. It then fills every bucket with descending timestamps, so each head needs a full sort, and measures the wait before each pop. A head that was never sorted, or a sort that is too slow, would show up as wrong order or an excessive wait. Further tests cover an insert into the already-sorted head, timestamps just below the base and just past the last window after the base has moved, and a full-bucket reject. Each of these catches an off-by-one in the window index, a base that fails to advance, or a reject that silently corrupts a bucket.

// File: rtl/tbin_evq_pkg.sv
package tbin_evq_pkg;
  typedef enum logic [1:0] {
    ST_ACCEPT = 2'd0,
    ST_RANGE  = 2'd1,
    ST_FULL   = 2'd2
  } ins_status_e;
endpackage

// File: rtl/tbin_evq_locate.sv
module tbin_evq_locate #(
  parameter int TIME_W    = 16,
  parameter int NUM_SEG   = 4,
  parameter int SEG_SHIFT = 4,
  localparam int SEG_W    = $clog2(NUM_SEG)
) (
  input  logic [TIME_W-1:0] ins_time,
  input  logic [TIME_W-1:0] base_time,
  input  logic [SEG_W-1:0]  head_ptr,
  output logic              out_of_range,
  output logic [SEG_W-1:0]  rel_idx,
  output logic [SEG_W-1:0]  phys_idx
);
  logic [TIME_W-1:0] offset;
  logic [TIME_W-1:0] window;
  logic [SEG_W:0]    ring_sum;

  always_comb begin
    offset       = ins_time - base_time;
    window       = offset >> SEG_SHIFT;
    out_of_range = window >= TIME_W'(NUM_SEG);
    rel_idx      = window[SEG_W-1:0];
    ring_sum     = {1'b0, head_ptr} + {1'b0, rel_idx};
    if (ring_sum >= (SEG_W+1)'(NUM_SEG))
      ring_sum = ring_sum - (SEG_W+1)'(NUM_SEG);
    phys_idx     = ring_sum[SEG_W-1:0];
  end
endmodule

// File: rtl/tbin_evq_head.sv
module tbin_evq_head #(
  parameter int TIME_W    = 16,
  parameter int NUM_SEG   = 4,
  parameter int SEG_CAP   = 4,
  parameter int SEG_SHIFT = 4,
  localparam int SEG_W    = $clog2(NUM_SEG),
  localparam int CNT_W    = $clog2(SEG_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  head_cnt,
  input  logic              others_busy,
  input  logic              ins_to_head,
  output logic [SEG_W-1:0]  head_ptr,
  output logic [TIME_W-1:0] base_time,
  output logic              head_sorted,
  output logic [CNT_W-1:0]  sort_pos
);
  localparam logic [TIME_W-1:0] WIN = TIME_W'(1) << SEG_SHIFT;

  logic advance;
  assign advance = (head_cnt == '0) && others_busy && !ins_to_head;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_ptr    <= '0;
      base_time   <= '0;
      head_sorted <= 1'b1;
      sort_pos    <= CNT_W'(1);
    end else if (advance) begin
      head_ptr    <= (head_ptr == SEG_W'(NUM_SEG - 1)) ? '0 : head_ptr + 1'b1;
      base_time   <= base_time + WIN;
      head_sorted <= 1'b0;
      sort_pos    <= CNT_W'(1);
    end else if (!head_sorted) begin
      if (sort_pos < head_cnt)
        sort_pos <= sort_pos + 1'b1;
      else if (!ins_to_head)
        head_sorted <= 1'b1;
    end
  end
endmodule

// File: rtl/tbin_evq_bucket.sv
module tbin_evq_bucket #(
  parameter int TIME_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SEG_CAP = 4,
  localparam int ENT_W  = TIME_W + DATA_W,
  localparam int CNT_W  = $clog2(SEG_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_head,
  input  logic             head_sorted,
  input  logic [CNT_W-1:0] sort_pos,
  input  logic             do_ins,
  input  logic [ENT_W-1:0] ins_entry,
  input  logic             do_pop,
  output logic [CNT_W-1:0] cnt,
  output logic [ENT_W-1:0] front
);
  logic [ENT_W-1:0] slot   [SEG_CAP];
  logic [ENT_W-1:0] nxt    [SEG_CAP];
  logic [ENT_W-1:0] stage  [SEG_CAP];
  logic [CNT_W-1:0] cnt_r, cnt_n, at_idx, place;
  logic [ENT_W-1:0] mover;
  logic             shift_en;

  always_comb begin
    nxt      = slot;
    cnt_n    = cnt_r;
    shift_en = 1'b0;
    at_idx   = '0;
    mover    = ins_entry;
    place    = '0;
    if (do_pop) begin
      for (int j = 0; j < SEG_CAP - 1; j++) nxt[j] = slot[j+1];
      cnt_n = cnt_r - 1'b1;
    end
    if (is_head && !head_sorted && sort_pos < cnt_r) begin
      shift_en = 1'b1;
      at_idx   = sort_pos;
      for (int j = 0; j < SEG_CAP; j++)
        if (CNT_W'(j) == sort_pos) mover = slot[j];
    end else if (do_ins && is_head && head_sorted) begin
      shift_en = 1'b1;
      at_idx   = cnt_n;
      mover    = ins_entry;
    end
    stage = nxt;
    if (shift_en) begin
      for (int j = 0; j < SEG_CAP; j++)
        if (CNT_W'(j) < at_idx && stage[j][ENT_W-1 -: TIME_W] <= mover[ENT_W-1 -: TIME_W])
          place = place + 1'b1;
      for (int j = 0; j < SEG_CAP; j++) begin
        if (CNT_W'(j) > place && CNT_W'(j) <= at_idx) nxt[j] = stage[j-1];
        else if (CNT_W'(j) == place) nxt[j] = mover;
      end
    end
    if (do_ins && !(is_head && head_sorted)) begin
      for (int j = 0; j < SEG_CAP; j++)
        if (CNT_W'(j) == cnt_n) nxt[j] = ins_entry;
    end
    if (do_ins) cnt_n = cnt_n + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_r <= '0;
    else     cnt_r <= cnt_n;
  end

  always_ff @(posedge clk) begin
    slot <= nxt;
  end

  assign cnt   = cnt_r;
  assign front = slot[0];
endmodule

// File: rtl/tbin_evq.sv
module tbin_evq #(
  parameter int TIME_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_SEG   = 4,
  parameter int SEG_CAP   = 4,
  parameter int SEG_SHIFT = 4,
  localparam int SEG_W    = $clog2(NUM_SEG),
  localparam int CNT_W    = $clog2(SEG_CAP + 1),
  localparam int TOT_W    = $clog2(NUM_SEG * SEG_CAP + 1),
  localparam int ENT_W    = TIME_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [TIME_W-1:0] ins_time,
  input  logic [DATA_W-1:0] ins_data,
  output logic              ins_overflow,
  output logic              ins_seg_full,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [TIME_W-1:0] pop_time,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty
);
  import tbin_evq_pkg::*;

  logic [TIME_W-1:0] base_time;
  logic [SEG_W-1:0]  head_ptr, rel_idx, phys_idx;
  logic              head_sorted, out_of_range, target_full, ins_ok, pop_fire, ins_to_head;
  logic [CNT_W-1:0]  sort_pos, head_cnt;
  logic [CNT_W-1:0]  seg_cnt   [NUM_SEG];
  logic [ENT_W-1:0]  seg_front [NUM_SEG];
  logic [TOT_W-1:0]  total;
  ins_status_e       status;

  tbin_evq_locate #(.TIME_W(TIME_W), .NUM_SEG(NUM_SEG), .SEG_SHIFT(SEG_SHIFT)) u_locate (
    .ins_time(ins_time), .base_time(base_time), .head_ptr(head_ptr),
    .out_of_range(out_of_range), .rel_idx(rel_idx), .phys_idx(phys_idx)
  );

  assign target_full = seg_cnt[phys_idx] == CNT_W'(SEG_CAP);
  assign status      = out_of_range ? ST_RANGE : (target_full ? ST_FULL : ST_ACCEPT);
  assign ins_ok      = ins_valid && (status == ST_ACCEPT);
  assign ins_to_head = ins_ok && (rel_idx == '0);
  assign head_cnt    = seg_cnt[head_ptr];
  assign pop_valid   = head_sorted && (head_cnt != '0);
  assign pop_fire    = pop_valid && pop_ready;
  assign pop_time    = seg_front[head_ptr][ENT_W-1 -: TIME_W];
  assign pop_data    = seg_front[head_ptr][DATA_W-1:0];

  tbin_evq_head #(.TIME_W(TIME_W), .NUM_SEG(NUM_SEG), .SEG_CAP(SEG_CAP), .SEG_SHIFT(SEG_SHIFT)) u_head (
    .clk(clk), .rst(rst), .head_cnt(head_cnt),
    .others_busy(total != TOT_W'(head_cnt)), .ins_to_head(ins_to_head),
    .head_ptr(head_ptr), .base_time(base_time), .head_sorted(head_sorted), .sort_pos(sort_pos)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_bucket
    tbin_evq_bucket #(.TIME_W(TIME_W), .DATA_W(DATA_W), .SEG_CAP(SEG_CAP)) u_bucket (
      .clk(clk), .rst(rst),
      .is_head(head_ptr == SEG_W'(g)), .head_sorted(head_sorted), .sort_pos(sort_pos),
      .do_ins(ins_ok && phys_idx == SEG_W'(g)), .ins_entry({ins_time, ins_data}),
      .do_pop(pop_fire && head_ptr == SEG_W'(g)),
      .cnt(seg_cnt[g]), .front(seg_front[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_overflow <= 1'b0;
      ins_seg_full <= 1'b0;
      total        <= '0;
      full         <= 1'b0;
      empty        <= 1'b1;
    end else begin
      ins_overflow <= ins_valid && (status == ST_RANGE);
      ins_seg_full <= ins_valid && (status == ST_FULL);
      total        <= total + TOT_W'(ins_ok) - TOT_W'(pop_fire);
      full         <= (total + TOT_W'(ins_ok) - TOT_W'(pop_fire)) == TOT_W'(NUM_SEG * SEG_CAP);
      empty        <= (total + TOT_W'(ins_ok) - TOT_W'(pop_fire)) == '0;
    end
  end
endmodule

// File: rtl/tbin_evq_chk.sv
module tbin_evq_chk #(
  parameter int SEG_CAP = 4,
  localparam int CNT_W  = $clog2(SEG_CAP + 1),
  localparam int WAIT_W = $clog2(2 * SEG_CAP + 2) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic             ins_overflow,
  input logic             ins_seg_full,
  input logic             pop_valid,
  input logic             full,
  input logic             empty,
  input logic [CNT_W-1:0] head_cnt
);
  logic [WAIT_W-1:0] stall;

  always_ff @(posedge clk) begin
    if (rst)                               stall <= '0;
    else if (pop_valid || head_cnt == '0)  stall <= '0;
    else                                   stall <= stall + 1'b1;
  end

  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (empty && !full && !pop_valid));

  // R8
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R8
  valid_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> !empty);

  // R2
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ins_overflow |-> $past(ins_valid));

  // R3
  seg_full_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ins_seg_full |-> ($past(ins_valid) && !ins_overflow));

  // R5
  sort_latency_chk: assert property (@(posedge clk) disable iff (rst)
    stall <= WAIT_W'(2 * SEG_CAP));
endmodule

bind tbin_evq tbin_evq_chk #(.SEG_CAP(SEG_CAP)) u_tbin_evq_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_overflow(ins_overflow),
  .ins_seg_full(ins_seg_full), .pop_valid(pop_valid), .full(full), .empty(empty),
  .head_cnt(head_cnt)
);

// File: tb/tbin_evq_bench.sv
module tbin_evq_bench;
  localparam int TIME_W = 16, DATA_W = 8, NUM_SEG = 4, SEG_CAP = 4, SEG_SHIFT = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic ins_valid = 1'b0, pop_ready = 1'b0;
  logic [TIME_W-1:0] ins_time = '0;
  logic [DATA_W-1:0] ins_data = '0;
  logic ins_overflow, ins_seg_full, pop_valid, full, empty;
  logic [TIME_W-1:0] pop_time;
  logic [DATA_W-1:0] pop_data;

  int tests = 0, fails = 0;
  int mt [32];
  int md [32];
  int mn = 0;

  always #5 clk = ~clk;

  tbin_evq #(.TIME_W(TIME_W), .DATA_W(DATA_W), .NUM_SEG(NUM_SEG), .SEG_CAP(SEG_CAP),
             .SEG_SHIFT(SEG_SHIFT)) u_tbin_evq (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_time(ins_time), .ins_data(ins_data),
    .ins_overflow(ins_overflow), .ins_seg_full(ins_seg_full), .pop_valid(pop_valid),
    .pop_ready(pop_ready), .pop_time(pop_time), .pop_data(pop_data), .full(full), .empty(empty)
  );

  // {time, data, expected status}: status 0 accepted, 1 out of range, 2 bucket full
  localparam logic [31:0] VEC [10] = '{
    {16'd5,  8'd1,  8'd0}, {16'd3,  8'd2,  8'd0}, {16'd20, 8'd3,  8'd0},
    {16'd64, 8'd4,  8'd1}, {16'd63, 8'd5,  8'd0}, {16'd3,  8'd6,  8'd0},
    {16'd10, 8'd7,  8'd0}, {16'd0,  8'd8,  8'd2}, {16'd40, 8'd9,  8'd0},
    {16'd16, 8'd10, 8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic insert(input int t, input int d, input int exp_stat, input string req);
    ins_valid = 1'b1; ins_time = TIME_W'(t); ins_data = DATA_W'(d);
    @(negedge clk);
    ins_valid = 1'b0;
    chk(req, {30'd0, ins_seg_full, ins_overflow}, exp_stat);
    if (exp_stat == 0) begin mt[mn] = t; md[mn] = d; mn++; end
  endtask

  task automatic pop_one(input int et, input int ed, input string req, output int waited);
    waited = 0;
    while (!pop_valid && waited < 4 * SEG_CAP) begin @(negedge clk); waited++; end
    chk({req, " valid"}, int'(pop_valid), 1);
    chk({req, " time"}, int'(pop_time), et);
    chk({req, " data"}, int'(pop_data), ed);
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
  endtask

  task automatic drain(input string req, input bit check_wait);
    int w;
    for (int i = 1; i < mn; i++) begin
      int kt = mt[i], kd = md[i], j = i;
      while (j > 0 && mt[j-1] > kt) begin mt[j] = mt[j-1]; md[j] = md[j-1]; j--; end
      mt[j] = kt; md[j] = kd;
    end
    for (int i = 0; i < mn; i++) begin
      pop_one(mt[i], md[i], req, w);
      if (check_wait) chk("R5 sort wait within SEG_CAP+2", int'(w <= SEG_CAP + 2), 1);
    end
    mn = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 pop_valid", int'(pop_valid), 0);
    chk("R1 flags", int'({ins_overflow, ins_seg_full}), 0);

    // R9: ready with nothing valid
    pop_ready = 1'b1; @(negedge clk); pop_ready = 1'b0;
    chk("R9 empty kept", int'(empty), 1);
    chk("R9 valid kept", int'(pop_valid), 0);

    // vector table: R2 window index, R3 bucket full
    for (int i = 0; i < 10; i++)
      insert(int'(VEC[i][31:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]), "R2/R3 table insert");
    chk("R8 not empty", int'(empty), 0);
    drain("R4 table order", 1'b0);
    @(negedge clk);
    chk("R8 empty after drain", int'(empty), 1);

    // base has advanced to 48 (R6)
    insert(47, 1, 1, "R6 below advanced base");
    insert(112, 1, 1, "R6 past last window");

    // R7: sorted placement into drained head
    insert(60, 21, 0, "R7 insert");
    insert(50, 22, 0, "R7 insert");
    pop_one(50, 22, "R7 first", w);
    insert(55, 23, 0, "R7 insert while draining");
    pop_one(55, 23, "R7 middle", w);
    pop_one(60, 21, "R7 last", w);
    mn = 0;

    // fill every bucket with descending times
    for (int s = 0; s < NUM_SEG; s++)
      for (int k = 0; k < SEG_CAP; k++)
        insert(48 + 16 * s + 15 - 3 * k, 100 + 4 * s + k, 0, "R2 fill");
    chk("R8 full", int'(full), 1);
    insert(50, 200, 2, "R3 full bucket");
    insert(112, 201, 1, "R2 range while full");
    chk("R8 still full", int'(full), 1);
    drain("R4 full order", 1'b1);
    @(negedge clk);
    chk("R8 empty end", int'(empty), 1);
    chk("R8 not full end", int'(full), 0);
    insert(95, 1, 1, "R6 base moved to 96");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule